// File: doc/BRIEF.md
# Registered Buffer with Chip-Select Gating

This block is the input register of a wide command and address buffer. Every rising clock edge captures a data word and a small group of chip-select lines and presents them on registered outputs. A static configuration bit picks one of two output pin maps, so the same part can serve either side of a module layout.

Two power features shape the behaviour. An active-low reset, asynchronous to the clock, clears every register at once and drives all outputs low. A low-power active mode freezes the data outputs while the gating enable and the first two chip selects are all high at a clock edge. The chip-select outputs keep updating in that mode, so that the memory side still sees the deselect. The gating decision uses the inputs sampled at the same edge that would otherwise load the data register.

Top module: `regbuf_csgate`

## Requirements
- R1: While `rstN` is low, `qOut` and `csOut` are all zero, regardless of the clock; the clear takes effect without waiting for a clock edge.
- R2: When `gateEn`, `csIn[0]` and `csIn[1]` are all 1 at a rising edge, `qOut` keeps its previous value after that edge.
- R3: With `cfgB` = 0 and the gating condition false (`gateEn` = 0, or `csIn[0]` = 0, or `csIn[1]` = 0), `qOut` equals the `dIn` sampled at the preceding rising edge, bit for bit.
- R4: `csOut` equals the `csIn` sampled at the preceding rising edge on every edge, whether or not the data is gated.
- R5: After reset is released, `qOut` stays all zero for as long as `dIn` is held at zero.
- R6: With `cfgB` = 1 and the gating condition false, the two halves swap: `qOut[DATA_W/2-1:0]` shows the sampled `dIn[DATA_W-1:DATA_W/2]` and `qOut[DATA_W-1:DATA_W/2]` shows the sampled `dIn[DATA_W/2-1:0]`.
- R7: Chip selects 2 and 3 play no part in the gating decision: with `gateEn`, `csIn[0]` and `csIn[1]` all 1, `qOut` holds whatever the values of `csIn[3:2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| dIn | input | DATA_W (28) | Data word to be registered |
| csIn | input | CS_N (4) | Chip-select lines, active low |
| gateEn | input | 1 | Enables output gating in low-power active mode |
| cfgB | input | 1 | Static pin-map select: 0 straight, 1 halves swapped |
| qOut | output | DATA_W (28) | Registered data word after pin mapping |
| csOut | output | CS_N (4) | Registered chip-select lines |

## Verification
Every data and chip-select result appears one rising edge after the inputs that cause it, whereas the reset clear appears at once, without an edge. The driver sets inputs at the falling edge, works out the outcome of the coming rising edge from the requirements, and queues it. The monitor compares each queued item one time unit after that rising edge. The reset clear is checked one time unit after `rstN` falls in mid-cycle, before any clock edge can mask it.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  // index of the chip selects that take part in the gating decision
  localparam int GATE_CS_LO = 0;
  localparam int GATE_CS_HI = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic loadCs;
  } ctrlStrobes_t;

endpackage

// File: rtl/regbuf_ctrl.sv
module regbuf_ctrl
  import regbuf_pkg::*;
#(
  parameter int CS_N = 4
) (
  input  logic            gateEn,
  input  logic [CS_N-1:0] csIn,
  output ctrlStrobes_t    strobes
);

  logic holdData;

  // gating looks at the inputs present at the loading edge
  assign holdData = gateEn & csIn[GATE_CS_LO] & csIn[GATE_CS_HI];

  always_comb begin
    strobes.loadData = ~holdData;
    strobes.loadCs   = 1'b1;
  end

endmodule

// File: rtl/regbuf_dp.sv
module regbuf_dp
  import regbuf_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int CS_N   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] dIn,
  input  logic [CS_N-1:0]   csIn,
  input  logic              cfgB,
  output logic [DATA_W-1:0] qOut,
  output logic [CS_N-1:0]   csOut
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] dataR;
  logic [CS_N-1:0]   csR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataR <= '0;
    end else if (strobes.loadData) begin
      dataR <= dIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csR <= '0;
    end else if (strobes.loadCs) begin
      csR <= csIn;
    end
  end

  // pin map: straight, or upper and lower halves exchanged
  for (genvar i = 0; i < DATA_W; i++) begin : g_map
    localparam int SWAP_IDX = (i + HALF_W) % DATA_W;
    assign qOut[i] = cfgB ? dataR[SWAP_IDX] : dataR[i];
  end

  assign csOut = csR;

endmodule

// File: rtl/regbuf_csgate.sv
module regbuf_csgate
  import regbuf_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int CS_N   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  logic [CS_N-1:0]   csIn,
  input  logic              gateEn,
  input  logic              cfgB,
  output logic [DATA_W-1:0] qOut,
  output logic [CS_N-1:0]   csOut
);

  ctrlStrobes_t strobes;

  regbuf_ctrl #(
    .CS_N(CS_N)
  ) i_ctrl (
    .gateEn (gateEn),
    .csIn   (csIn),
    .strobes(strobes)
  );

  regbuf_dp #(
    .DATA_W(DATA_W),
    .CS_N  (CS_N)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dIn    (dIn),
    .csIn   (csIn),
    .cfgB   (cfgB),
    .qOut   (qOut),
    .csOut  (csOut)
  );

endmodule

// File: rtl/regbuf_chk.sv
module regbuf_chk #(
  parameter int DATA_W = 28,
  parameter int CS_N   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dIn,
  input logic [CS_N-1:0]   csIn,
  input logic              gateEn,
  input logic              cfgB,
  input logic [DATA_W-1:0] qOut,
  input logic [CS_N-1:0]   csOut
);

  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] swapHalves(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[(i + HALF_W) % DATA_W];
    return r;
  endfunction

  logic gateCond;
  assign gateCond = gateEn && csIn[0] && csIn[1];

  // R1
  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      reset_clear_chk: assert (qOut == '0 && csOut == '0);
    end
  end

  // R2
  hold_when_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateCond |=> $stable(qOut));

  // R3
  follow_straight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gateCond && !cfgB) |=> (qOut == $past(dIn)));

  // R4
  cs_always_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (csOut == $past(csIn)));

  // R5
  stay_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dIn == '0 && qOut == '0 && !gateCond) |=> (qOut == '0));

  // R6
  follow_swapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gateCond && cfgB) |=> (qOut == swapHalves($past(dIn))));

  // R7
  upper_cs_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateCond && csIn[3:2] != 2'b11) |=> $stable(qOut));

endmodule

bind regbuf_csgate regbuf_chk #(
  .DATA_W(DATA_W),
  .CS_N  (CS_N)
) i_chk (
  .clk   (clk),
  .rstN  (rstN),
  .dIn   (dIn),
  .csIn  (csIn),
  .gateEn(gateEn),
  .cfgB  (cfgB),
  .qOut  (qOut),
  .csOut (csOut)
);

// File: tb/test_regbuf_csgate.sv
`timescale 1ns/1ps
module test_regbuf_csgate;

  localparam int DATA_W = 28;
  localparam int CS_N   = 4;
  localparam int HALF_W = DATA_W / 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] dIn = '0;
  logic [CS_N-1:0]   csIn = '0;
  logic              gateEn = 1'b0;
  logic              cfgB = 1'b0;
  logic [DATA_W-1:0] qOut;
  logic [CS_N-1:0]   csOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [DATA_W-1:0] qExp;
    logic [CS_N-1:0]   csExp;
    string             tag;
  } item_t;

  item_t expQ[$];
  logic [DATA_W-1:0] modelData = '0;

  always #5 clk = ~clk;

  regbuf_csgate #(.DATA_W(DATA_W), .CS_N(CS_N)) i_regbuf_csgate (
    .clk(clk), .rstN(rstN), .dIn(dIn), .csIn(csIn), .gateEn(gateEn),
    .cfgB(cfgB), .qOut(qOut), .csOut(csOut)
  );

  function automatic logic [DATA_W-1:0] mapOut(input logic [DATA_W-1:0] v, input logic b);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = b ? v[(i + HALF_W) % DATA_W] : v[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] aq, input logic [DATA_W-1:0] eq,
                       input logic [CS_N-1:0] ac, input logic [CS_N-1:0] ec);
    checks++;
    if (aq !== eq || ac !== ec) begin
      fails++;
      $display("FAIL %s: qOut=%h csOut=%h expected qOut=%h csOut=%h", tag, aq, ac, eq, ec);
    end
  endtask

  // driver: drive at falling edge, queue the result of the next rising edge
  task automatic step(input logic [DATA_W-1:0] d, input logic [CS_N-1:0] cs,
                      input logic g, input string tag);
    item_t it;
    @(negedge clk);
    dIn = d; csIn = cs; gateEn = g;
    if (!(g && cs[0] && cs[1])) modelData = d;
    it.qExp = mapOut(modelData, cfgB);
    it.csExp = cs;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(it.tag, qOut, it.qExp, csOut, it.csExp);
      end
    end
  end

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 reset state", qOut, '0, csOut, '0);

    // R5: release with zero data, outputs stay low
    @(negedge clk);
    rstN = 1'b1;
    step('0, 4'hC, 1'b0, "R5 low after release");
    step('0, 4'hF, 1'b0, "R5 low after release");
    step('0, 4'h0, 1'b0, "R5 low after release");

    // R3: normal follow in straight mapping
    step(28'hABCDEF1, 4'h0, 1'b0, "R3 follow");
    step(28'h5A5A5A5, 4'h3, 1'b0, "R3 follow gate off");
    step(28'hFFFFFFF, 4'hE, 1'b1, "R3 follow cs0 low");
    step(28'h0123456, 4'hD, 1'b1, "R3 follow cs1 low");

    // R2 / R4: gated hold, chip selects still update
    step(28'h1111111, 4'h3, 1'b1, "R2 hold");
    step(28'h2222222, 4'hF, 1'b1, "R4 cs updates while held");

    // R7: upper chip selects do not affect gating
    step(28'h3333333, 4'h7, 1'b1, "R7 cs3 low still holds");
    step(28'h4444444, 4'hB, 1'b1, "R7 cs2 low still holds");
    step(28'h5555555, 4'h0, 1'b0, "R3 resume after hold");
    drain();

    // R1: asynchronous reset mid-cycle
    @(negedge clk);
    #2;
    rstN = 1'b0;
    #1;
    check("R1 async clear", qOut, '0, csOut, '0);
    modelData = '0;

    // R6: swapped mapping, set while in reset
    cfgB = 1'b1;
    dIn = '0; csIn = '0; gateEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    step(28'h000ABCD, 4'h0, 1'b0, "R6 swap low half");
    step(28'hFED0000, 4'h2, 1'b0, "R6 swap high half");
    step(28'h1234567, 4'h3, 1'b1, "R2 hold in swapped map");
    step(28'h89ABCDE, 4'h1, 1'b1, "R6 swap cs1 low");
    drain();
    @(negedge clk);
    finishRun();
  end

endmodule